// File: doc/BRIEF.md
# Multi-mode program bank mapper

This block maps CPU accesses in the upper 32K of a 16-bit address space (8000h-FFFFh) onto banked program ROM or work RAM. Software picks one of four ways to split that window at run time: a single 32K page, two 16K pages, a 16K page followed by two 8K pages, or four 8K pages. It makes the choice through a small set of write-only registers. The layout register sits at 5100h, and four page registers sit at 5114h-5117h. Each page register covers one quarter of the window, from the bottom quarter up to the top quarter.

For every access inside the window, the mapper raises exactly one of two steering strobes, ROM or RAM. It also produces a bank-qualified address for that memory. Bit 7 of the three lower page registers decides between RAM and ROM for the pages they control. The top page always comes from ROM. When a page is larger than 8K, the low bank bits that the page size covers come from the CPU address instead of the register.

A write to a page register that the current layout does not use is discarded. The stored value therefore survives a change to a layout that does use that register. The translation path is purely combinational from `cpu_addr`. Register writes land on the rising clock edge.

Top module: `pbank_mapper`

## Requirements
- R1: After synchronous reset the layout is four 8K pages (code 11). The register at 5117h holds 7Fh and the registers at 5114h-5116h hold FFh. An access at E000h-FFFFh therefore reads ROM bank 7Fh.
- R2: An access with cpu_addr[15]=1 asserts exactly one of rom_sel and ram_sel. An access with cpu_addr[15]=0 asserts neither.
- R3: With layout code 00, the whole window is ROM. The bank is {reg5117[6:2], cpu_addr[14:13]}, so writing 84h-87h to 5117h selects the same 32K page.
- R4: With layout code 01, 8000h-BFFFh uses bank {reg5115[6:1], cpu_addr[13]} and C000h-FFFFh uses bank {reg5117[6:1], cpu_addr[13]}.
- R5: With layout code 10, 8000h-BFFFh uses bank {reg5115[6:1], cpu_addr[13]}. C000h-DFFFh uses reg5116[6:0] and E000h-FFFFh uses reg5117[6:0].
- R6: With layout code 11, the quarter selected by cpu_addr[14:13] (0 to 3) uses register 5114h+quarter, bits 6:0, as its bank.
- R7: For pages served by 5114h, 5115h or 5116h, bit 7 = 0 steers to RAM and bit 7 = 1 steers to ROM. Bit 7 of 5117h is ignored, and E000h-FFFFh is always ROM.
- R8: Writes are discarded in three cases: a write to 5114h-5116h while the current layout does not use that register, a write to any address other than 5100h and 5114h-5117h, and a write to 5100h beyond its low two bits.
- R9: rom_addr is {bank[6:0], cpu_addr[12:0]} and ram_addr is {bank[2:0], cpu_addr[12:0]}. For a 16K RAM page, bank bit 0 comes from cpu_addr[13].
- R10: A register write with wr_en high is visible in the mapping from the cycle after the rising edge that captures it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 16 | Register write address |
| wr_data | input | 8 | Register write data |
| cpu_addr | input | 16 | CPU access address to translate |
| rom_sel | output | 1 | Access steered to program ROM |
| ram_sel | output | 1 | Access steered to work RAM |
| rom_addr | output | 20 | ROM address: bank and in-page offset |
| ram_addr | output | 16 | RAM address: low bank bits and offset |

## Verification
The properties assume that `cpu_addr` is steady whenever the strobes are sampled. They also assume that a write strobe lasts exactly one clock, with address and data valid throughout it. The stimulus drives every input just after a falling edge and holds it across the following rising edge. It then moves `cpu_addr` only between edges, so each combinational read settles before it is compared. Random writes mix legal register addresses with neighbouring unused ones and arbitrary data, including bit-7 patterns on every register. This lets layout switches expose values that earlier writes left in registers the previous layout ignored.

// File: rtl/pbank_pkg.sv
package pbank_pkg;

    localparam int CPU_AW        = 16;
    localparam int DATA_W        = 8;
    localparam int BANK_W        = 7;
    localparam int OFFS_W        = 13;
    localparam int RAM_BANK_W    = 3;
    localparam int NUM_PAGE_REGS = 4;
    localparam int SLOT_W        = CPU_AW - 1 - OFFS_W;
    localparam int ROM_AW        = BANK_W + OFFS_W;
    localparam int RAM_AW        = RAM_BANK_W + OFFS_W;
    localparam int IDX_W         = $clog2(NUM_PAGE_REGS);
    localparam int TYPE_BIT      = DATA_W - 1;

    localparam logic [CPU_AW-1:0] ADDR_LAYOUT    = 16'h5100;
    localparam logic [CPU_AW-1:0] ADDR_PAGE_BASE = 16'h5114;

    localparam logic [DATA_W-1:0] PAGE_RST = 8'hFF;
    localparam logic [DATA_W-1:0] TOP_RST  = 8'h7F;

    typedef enum logic [1:0] {
        LAY_ONE32  = 2'b00,
        LAY_TWO16  = 2'b01,
        LAY_MIXED  = 2'b10,
        LAY_FOUR8  = 2'b11
    } layout_e;

    localparam layout_e LAYOUT_RST = LAY_FOUR8;

    typedef enum logic [1:0] {
        SZ_8K  = 2'b00,
        SZ_16K = 2'b01,
        SZ_32K = 2'b10
    } page_size_e;

    typedef struct packed {
        logic [IDX_W-1:0] reg_idx;
        page_size_e       size;
        logic             typed;
    } page_pick_t;

    typedef struct packed {
        logic              to_ram;
        logic [BANK_W-1:0] bank;
    } route_t;

    function automatic logic reg_live(input layout_e lay, input logic [IDX_W-1:0] idx);
        logic live;
        case (idx)
            2'd0:    live = (lay == LAY_FOUR8);
            2'd1:    live = (lay != LAY_ONE32);
            2'd2:    live = (lay == LAY_MIXED) || (lay == LAY_FOUR8);
            default: live = 1'b1;
        endcase
        return live;
    endfunction

    function automatic page_pick_t pick_page(input layout_e lay, input logic [SLOT_W-1:0] slot);
        page_pick_t p;
        p.reg_idx = IDX_W'(NUM_PAGE_REGS - 1);
        p.size    = SZ_8K;
        p.typed   = 1'b0;
        case (lay)
            LAY_ONE32: begin
                p.size = SZ_32K;
            end
            LAY_TWO16: begin
                p.size = SZ_16K;
                if (!slot[1]) begin
                    p.reg_idx = 2'd1;
                    p.typed   = 1'b1;
                end
            end
            LAY_MIXED: begin
                if (!slot[1]) begin
                    p.reg_idx = 2'd1;
                    p.size    = SZ_16K;
                    p.typed   = 1'b1;
                end else if (!slot[0]) begin
                    p.reg_idx = 2'd2;
                    p.typed   = 1'b1;
                end
            end
            default: begin
                p.reg_idx = slot;
                p.typed   = (slot != 2'd3);
            end
        endcase
        return p;
    endfunction

endpackage

// File: rtl/pbank_regs.sv
module pbank_regs
    import pbank_pkg::*;
(
    input  logic                                 clk,
    input  logic                                 rst,
    input  logic                                 wr_en,
    input  logic [CPU_AW-1:0]                    wr_addr,
    input  logic [DATA_W-1:0]                    wr_data,
    output layout_e                              layout_q,
    output logic [NUM_PAGE_REGS-1:0][DATA_W-1:0] page_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            layout_q <= LAYOUT_RST;
        end else if (wr_en && wr_addr == ADDR_LAYOUT) begin
            layout_q <= layout_e'(wr_data[1:0]);
        end
    end

    for (genvar g = 0; g < NUM_PAGE_REGS; g++) begin : g_page
        localparam logic [CPU_AW-1:0] MY_ADDR = ADDR_PAGE_BASE + CPU_AW'(g);
        localparam logic [DATA_W-1:0] RST_V   = (g == NUM_PAGE_REGS - 1) ? TOP_RST : PAGE_RST;
        localparam logic [IDX_W-1:0]  MY_IDX  = IDX_W'(g);

        logic hit;
        assign hit = wr_en && (wr_addr == MY_ADDR) && reg_live(layout_q, MY_IDX);

        always_ff @(posedge clk) begin
            if (rst) begin
                page_q[g] <= RST_V;
            end else if (hit) begin
                page_q[g] <= wr_data;
            end
        end
    end

endmodule

// File: rtl/pbank_page_pick.sv
module pbank_page_pick
    import pbank_pkg::*;
(
    input  layout_e                              layout_q,
    input  logic [SLOT_W-1:0]                    slot,
    input  logic [NUM_PAGE_REGS-1:0][DATA_W-1:0] page_q,
    output page_pick_t                           pick,
    output logic [DATA_W-1:0]                    reg_val
);

    always_comb begin
        pick    = pick_page(layout_q, slot);
        reg_val = page_q[pick.reg_idx];
    end

endmodule

// File: rtl/pbank_compose.sv
module pbank_compose
    import pbank_pkg::*;
(
    input  page_pick_t          pick,
    input  logic [DATA_W-1:0]   reg_val,
    input  logic [SLOT_W-1:0]   slot,
    input  logic [OFFS_W-1:0]   offset,
    output route_t              route,
    output logic [ROM_AW-1:0]   rom_addr,
    output logic [RAM_AW-1:0]   ram_addr
);

    logic [BANK_W-1:0] raw;

    always_comb begin
        raw = reg_val[BANK_W-1:0];
        case (pick.size)
            SZ_32K:  route.bank = {raw[BANK_W-1:SLOT_W], slot};
            SZ_16K:  route.bank = {raw[BANK_W-1:1], slot[0]};
            default: route.bank = raw;
        endcase
        route.to_ram = pick.typed & ~reg_val[TYPE_BIT];
        rom_addr     = {route.bank, offset};
        ram_addr     = {route.bank[RAM_BANK_W-1:0], offset};
    end

endmodule

// File: rtl/pbank_mapper.sv
module pbank_mapper
    import pbank_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [CPU_AW-1:0]    wr_addr,
    input  logic [DATA_W-1:0]    wr_data,
    input  logic [CPU_AW-1:0]    cpu_addr,
    output logic                 rom_sel,
    output logic                 ram_sel,
    output logic [ROM_AW-1:0]    rom_addr,
    output logic [RAM_AW-1:0]    ram_addr
);

    layout_e                              layout_q;
    logic [NUM_PAGE_REGS-1:0][DATA_W-1:0] page_q;
    page_pick_t                           pick;
    logic [DATA_W-1:0]                    reg_val;
    route_t                               route;
    logic [SLOT_W-1:0]                    slot;
    logic                                 in_window;

    assign slot      = cpu_addr[CPU_AW-2:OFFS_W];
    assign in_window = cpu_addr[CPU_AW-1];

    pbank_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .layout_q (layout_q),
        .page_q   (page_q)
    );

    pbank_page_pick u_pick (
        .layout_q (layout_q),
        .slot     (slot),
        .page_q   (page_q),
        .pick     (pick),
        .reg_val  (reg_val)
    );

    pbank_compose u_compose (
        .pick     (pick),
        .reg_val  (reg_val),
        .slot     (slot),
        .offset   (cpu_addr[OFFS_W-1:0]),
        .route    (route),
        .rom_addr (rom_addr),
        .ram_addr (ram_addr)
    );

    assign rom_sel = in_window & ~route.to_ram;
    assign ram_sel = in_window &  route.to_ram;

endmodule

// File: rtl/pbank_mapper_chk.sv
module pbank_mapper_chk
    import pbank_pkg::*;
(
    input logic                                 clk,
    input logic                                 rst,
    input logic                                 wr_en,
    input logic [CPU_AW-1:0]                    wr_addr,
    input logic [DATA_W-1:0]                    wr_data,
    input logic [CPU_AW-1:0]                    cpu_addr,
    input logic                                 rom_sel,
    input logic                                 ram_sel,
    input logic [ROM_AW-1:0]                    rom_addr,
    input logic [1:0]                           layout_q,
    input logic [NUM_PAGE_REGS-1:0][DATA_W-1:0] page_q
);

    p_window_one_r2: assert property (@(posedge clk) disable iff (rst)
        cpu_addr[CPU_AW-1] |-> (rom_sel ^ ram_sel));

    p_outside_idle_r2: assert property (@(posedge clk) disable iff (rst)
        !cpu_addr[CPU_AW-1] |-> !(rom_sel || ram_sel));

    p_top_rom_r7: assert property (@(posedge clk) disable iff (rst)
        (cpu_addr[CPU_AW-1] && cpu_addr[CPU_AW-2:OFFS_W] == 2'b11) |-> rom_sel);

    p_one32_rom_r3: assert property (@(posedge clk) disable iff (rst)
        (layout_q == 2'b00 && cpu_addr[CPU_AW-1])
            |-> (rom_sel && rom_addr[OFFS_W+1:OFFS_W] == cpu_addr[CPU_AW-2:OFFS_W]));

    p_two16_low_r4: assert property (@(posedge clk) disable iff (rst)
        (layout_q == 2'b01 && rom_sel) |-> (rom_addr[OFFS_W] == cpu_addr[OFFS_W]));

    p_dead_write_r8: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == ADDR_PAGE_BASE && layout_q != 2'b11) |=> $stable(page_q[0]));

    p_layout_write_r10: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == ADDR_LAYOUT) |=> (layout_q == $past(wr_data[1:0])));

endmodule

bind pbank_mapper pbank_mapper_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .cpu_addr (cpu_addr),
    .rom_sel  (rom_sel),
    .ram_sel  (ram_sel),
    .rom_addr (rom_addr),
    .layout_q (layout_q),
    .page_q   (page_q)
);

// File: tb/pbank_mapper_bench.sv
module pbank_mapper_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [15:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [15:0] cpu_addr = '0;
    logic        rom_sel;
    logic        ram_sel;
    logic [19:0] rom_addr;
    logic [15:0] ram_addr;

    int checks = 0;
    int errors = 0;

    logic [1:0] m_lay;
    logic [7:0] m_page [4];

    always #(CLK_PERIOD/2) clk = ~clk;

    pbank_mapper u_pbank_mapper (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .cpu_addr(cpu_addr), .rom_sel(rom_sel), .ram_sel(ram_sel),
        .rom_addr(rom_addr), .ram_addr(ram_addr)
    );

    function automatic bit live(input logic [1:0] lay, input int idx);
        case (idx)
            0: return lay == 2'b11;
            1: return lay != 2'b00;
            2: return lay[1];
            default: return 1'b1;
        endcase
    endfunction

    task automatic model_reset();
        m_lay = 2'b11;
        m_page[0] = 8'hFF; m_page[1] = 8'hFF; m_page[2] = 8'hFF; m_page[3] = 8'h7F;
    endtask

    task automatic write_reg(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (a == 16'h5100) m_lay = d[1:0];
        else if (a >= 16'h5114 && a <= 16'h5117 && live(m_lay, int'(a - 16'h5114)))
            m_page[a - 16'h5114] = d;
    endtask

    task automatic expect_route(input logic [15:0] a, output logic ram, output logic [6:0] bank);
        logic [1:0] s;
        s = a[14:13];
        ram = 1'b0;
        case (m_lay)
            2'b00: bank = {m_page[3][6:2], s};
            2'b01: begin
                if (s[1]) bank = {m_page[3][6:1], s[0]};
                else begin bank = {m_page[1][6:1], s[0]}; ram = ~m_page[1][7]; end
            end
            2'b10: begin
                if (!s[1]) begin bank = {m_page[1][6:1], s[0]}; ram = ~m_page[1][7]; end
                else if (!s[0]) begin bank = m_page[2][6:0]; ram = ~m_page[2][7]; end
                else bank = m_page[3][6:0];
            end
            default: begin
                bank = m_page[s][6:0];
                ram  = (s != 2'd3) && !m_page[s][7];
            end
        endcase
    endtask

    task automatic check_addr(input logic [15:0] a, input string req);
        logic       e_ram;
        logic [6:0] e_bank;
        cpu_addr = a;
        #1;
        checks++;
        if (!a[15]) begin
            if (rom_sel || ram_sel) begin
                errors++;
                $display("FAIL %s addr %h sels %b%b expected 00", req, a, rom_sel, ram_sel);
            end
        end else begin
            expect_route(a, e_ram, e_bank);
            if (rom_sel !== !e_ram || ram_sel !== e_ram) begin
                errors++;
                $display("FAIL %s addr %h rom/ram %b%b expected %b%b", req, a, rom_sel, ram_sel, !e_ram, e_ram);
            end else if (!e_ram && rom_addr !== {e_bank, a[12:0]}) begin
                errors++;
                $display("FAIL %s addr %h rom_addr %h expected %h", req, a, rom_addr, {e_bank, a[12:0]});
            end else if (e_ram && ram_addr !== {e_bank[2:0], a[12:0]}) begin
                errors++;
                $display("FAIL %s addr %h ram_addr %h expected %h", req, a, ram_addr, {e_bank[2:0], a[12:0]});
            end
        end
    endtask

    task automatic check_rom(input logic [15:0] a, input logic [19:0] exp, input string req);
        cpu_addr = a;
        #1;
        checks++;
        if (!rom_sel || rom_addr !== exp) begin
            errors++;
            $display("FAIL %s addr %h rom_sel %b rom_addr %h expected 1 %h", req, a, rom_sel, rom_addr, exp);
        end
    endtask

    function automatic string lay_tag(input logic [1:0] lay);
        case (lay)
            2'b00: return "R3";
            2'b01: return "R4";
            2'b10: return "R5";
            default: return "R6";
        endcase
    endfunction

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : stim
        logic [15:0] a;
        logic [7:0]  d;
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset contents
        check_rom(16'hE123, {7'h7F, 13'h0123}, "R1");
        check_addr(16'h8000, "R1");
        check_addr(16'hC456, "R1");
        // R2: below the window
        check_addr(16'h7FFF, "R2");
        check_addr(16'h0000, "R2");

        // R3: 84h..87h all give the same 32K page
        write_reg(16'h5100, 8'h00);
        for (int k = 4; k < 8; k++) begin
            write_reg(16'h5117, 8'h80 | 8'(k));
            check_rom(16'h8000, {7'd4, 13'h0000}, "R3");
            check_rom(16'hE001, {7'd7, 13'h0001}, "R3");
        end

        // R8: ignored writes while in layout 00
        write_reg(16'h5115, 8'h00);
        write_reg(16'h5114, 8'h00);
        write_reg(16'h5113, 8'h00);
        write_reg(16'h5100, 8'hFD);       // low bits 01
        check_rom(16'h8000, {7'h7E, 13'h0000}, "R8");
        check_rom(16'hA010, {7'h7F, 13'h0010}, "R8");

        // R7 and R9: 16K RAM page, bank bit 0 from address bit 13
        write_reg(16'h5115, 8'h05);
        check_addr(16'h8004, "R9");
        check_addr(16'hA004, "R9");
        checks++;
        if (!ram_sel || ram_addr !== {3'd5, 13'h0004}) begin
            errors++;
            $display("FAIL R9 ram_sel %b ram_addr %h expected 1 %h", ram_sel, ram_addr, {3'd5, 13'h0004});
        end

        // R7: top page ignores bit 7
        write_reg(16'h5100, 8'h03);
        write_reg(16'h5117, 8'h05);
        check_rom(16'hE000, {7'd5, 13'h0000}, "R7");
        write_reg(16'h5114, 8'h02);
        check_addr(16'h9FFF, "R7");

        // R5: mixed layout, 8K RAM page at C000h
        write_reg(16'h5100, 8'h02);
        write_reg(16'h5116, 8'h03);
        check_addr(16'hC100, "R5");
        checks++;
        if (!ram_sel || ram_addr !== {3'd3, 13'h0100}) begin
            errors++;
            $display("FAIL R5 ram_sel %b ram_addr %h expected 1 %h", ram_sel, ram_addr, {3'd3, 13'h0100});
        end
        write_reg(16'h5114, 8'h66);       // dead in layout 10
        write_reg(16'h5100, 8'h03);
        check_addr(16'h8000, "R8");

        // R10: write visible the cycle after capture
        @(negedge clk);
        cpu_addr = 16'hC000;
        wr_en = 1'b1; wr_addr = 16'h5116; wr_data = 8'hC1;
        #1;
        checks++;
        if (rom_sel || !ram_sel) begin
            errors++;
            $display("FAIL R10 early update rom/ram %b%b expected 01", rom_sel, ram_sel);
        end
        @(negedge clk);
        wr_en = 1'b0;
        m_page[2] = 8'hC1;
        check_rom(16'hC000, {7'h41, 13'h0000}, "R10");

        // random mix
        for (int i = 0; i < 600; i++) begin
            case ($urandom_range(0, 7))
                0, 1:    a = 16'h5100;
                2:       a = 16'h5113;
                3:       a = 16'h5118;
                default: a = 16'h5114 + 16'($urandom_range(0, 3));
            endcase
            d = 8'($urandom);
            write_reg(a, d);
            for (int j = 0; j < 4; j++) begin
                a = 16'($urandom);
                if (j == 0) a[15] = 1'b0;
                else        a[15] = 1'b1;
                check_addr(a, a[15] ? lay_tag(m_lay) : "R2");
            end
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule